// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block is the processor-side sequencer for a 32-bit address and data bus that can move several words per request. An internal requester hands it a byte address, a size code (1, 2, 4, 8 or 16 bytes), a read/write flag, a cycle kind and one word of write data. The sequencer opens a bus cycle with a one-clock address strobe. It then waits for the target's completion inputs and returns each read word to the requester, tagged with the word's slot inside its 16-byte line.

The number of transfers is settled from the request size and from the target's cache-enable reply, which is sampled before the first completion. Once that reply makes a memory read cacheable, the read grows to a four-word line fill. Words of one cycle always come from one 16-byte aligned line, in an interleaved order. A target that completes with the burst input lets the sequencer step to the next word without a new strobe. A target that completes with the plain ready input makes the sequencer open the next word with a fresh strobe, and the interleaved order still holds. Requests are assumed naturally aligned to their size, and write requests are at most 4 bytes.

Top module: `burst_bus_seq`

## Requirements
- R1: After reset the strobe and last outputs are high, req_ready is high and rd_valid is low.
- R2: A request is taken at a clock edge with req_valid and req_ready both high. bus_start_n is low for exactly the next clock, which is the address clock, and high in every wait clock.
- R3: bus_addr carries the request's address bits [31:4] and a 2-bit slot. Transfer i (counting from 0) uses slot = start slot XOR i, so a start at byte offset 4 gives the order 4, 0, C, 8. Address bits [31:4], bus_mem, bus_code and bus_write do not change while a cycle is in progress.
- R4: A cycle has 1 transfer for sizes of 1, 2 and 4 bytes, 2 for 8 bytes and 4 for 16 bytes. A data or code read becomes 4 transfers when tgt_cache_n is low at the last clock edge before its first completion.
- R5: bus_last_n is high in the address clock and during non-final transfers, and low in the wait clocks of the final transfer. After the final completion, req_ready is high in the next clock.
- R6: In a wait clock, tgt_done_n low or tgt_burst_n low completes a transfer. When both are low together, the completion counts as a plain ready completion.
- R7: A burst completion of a non-final read transfer (data, code or I/O kind) moves to the next word in the next clock without a strobe. A plain ready completion makes the next clock a new address clock.
- R8: For interrupt-acknowledge (kind 3) and halt (kind 4) cycles, a burst completion behaves exactly like a plain ready completion.
- R9: The first transfer drives active-low lane enables for the requested bytes: 2^size lanes starting at address bits [1:0], or all four lanes for 8 and 16 bytes. Every later transfer drives all four lanes low.
- R10: For each read completion, rd_valid is high for one clock in the next clock. It carries the bus_rdata value sampled at that edge and rd_slot holding the slot of that transfer. Write cycles never raise rd_valid.
- R11: Cycle kind encoding on req_kind: 0 memory data, 1 memory code, 2 I/O, 3 interrupt-acknowledge, 4 halt. bus_mem is 1 for kinds 0, 1 and 4. bus_code is 1 for kinds 1 and 3. bus_write follows req_write for kinds 0 and 2, is 0 for kinds 1 and 3, and is 1 for kind 4. bus_wdata holds req_wdata for the whole cycle.
- R12: tgt_cache_n has no effect after the first transfer of a cycle has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 3 | Size code, bytes = 2^code (0 to 4) |
| req_write | input | 1 | 1 for a write request |
| req_kind | input | 3 | Cycle kind code |
| req_wdata | input | 32 | Write data word |
| bus_start_n | output | 1 | Active-low address strobe |
| bus_addr | output | 30 | Word address, bits [31:2] |
| bus_lane_n | output | 4 | Active-low byte lane enables |
| bus_write | output | 1 | Write (1) or read (0) |
| bus_mem | output | 1 | Memory (1) or I/O (0) space |
| bus_code | output | 1 | Code/control (1) or data (0) |
| bus_last_n | output | 1 | Active-low final-transfer indication |
| bus_wdata | output | 32 | Write data to the bus |
| bus_rdata | input | 32 | Read data from the bus |
| tgt_done_n | input | 1 | Active-low plain ready completion |
| tgt_burst_n | input | 1 | Active-low burst ready completion |
| tgt_cache_n | input | 1 | Active-low cache-enable reply |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 32 | Returned read word |
| rd_slot | output | 2 | Slot of the returned word within its line |

## Verification
The strobe appears in the clock right after the accepting edge. The last indication and the lane enables are valid in every wait clock of a transfer and must be read before the completion edge. A returned word, the end-of-cycle return to idle and the next strobe after a plain completion all show up one clock after the completion edge. The bench drives all target inputs on the falling clock edge and reads the outputs at falling edges. It checks the last indication, address and lanes in the clock where it asserts completion. It checks rd_valid, rd_data, rd_slot, req_ready and the strobe at the falling edge that follows. Wait states before each completion vary, so values are also checked while the sequencer is held.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        KIND_DATA   = 3'd0,
        KIND_CODE   = 3'd1,
        KIND_IO     = 3'd2,
        KIND_INTACK = 3'd3,
        KIND_HALT   = 3'd4
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bseq_len.sv
// Transfer count of one cycle from the request size and the growth decision.
module bseq_len #(
    parameter int LINE_BYTES = 16,
    parameter int LANES      = 4,
    parameter int CNT_W      = 3
) (
    input  logic [2:0]       size,
    input  logic             grow,
    output logic [CNT_W-1:0] count
);
    localparam int SLOTS = LINE_BYTES / LANES;

    logic [31:0] nbytes;

    always_comb begin
        nbytes = 32'd1 << size;
        if (grow || nbytes >= 32'(LINE_BYTES)) begin
            count = CNT_W'(SLOTS);
        end else if (nbytes <= 32'(LANES)) begin
            count = CNT_W'(1);
        end else begin
            count = CNT_W'(nbytes / 32'(LANES));
        end
    end
endmodule

// File: rtl/bseq_order.sv
// Interleaved line order: each slot is the start slot XOR the transfer index.
module bseq_order #(
    parameter int SLOT_W = 2
) (
    input  logic [SLOT_W-1:0] start,
    input  logic [SLOT_W-1:0] idx,
    output logic [SLOT_W-1:0] slot
);
    genvar b;
    generate
        for (b = 0; b < SLOT_W; b++) begin : g_bit
            assign slot[b] = start[b] ^ idx[b];
        end
    endgenerate
endmodule

// File: rtl/bseq_lanes.sv
// Active-high lane selection for the first transfer of a request.
module bseq_lanes #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2
) (
    input  logic [2:0]        size,
    input  logic [LANE_W-1:0] off,
    output logic [LANES-1:0]  en
);
    logic [31:0] nbytes;
    logic [31:0] offx;
    logic        wide;

    assign nbytes = 32'd1 << size;
    assign offx   = 32'(off);
    assign wide   = nbytes >= 32'(LANES);

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            assign en[j] = wide || ((32'(j) >= offx) && (32'(j) < offx + nbytes));
        end
    endgenerate
endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2:0]            req_size,
    input  logic                  req_write,
    input  logic [2:0]            req_kind,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  bus_start_n,
    output logic [ADDR_W-1:2]     bus_addr,
    output logic [DATA_W/8-1:0]   bus_lane_n,
    output logic                  bus_write,
    output logic                  bus_mem,
    output logic                  bus_code,
    output logic                  bus_last_n,
    output logic [DATA_W-1:0]     bus_wdata,
    input  logic [DATA_W-1:0]     bus_rdata,
    input  logic                  tgt_done_n,
    input  logic                  tgt_burst_n,
    input  logic                  tgt_cache_n,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] rd_slot
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int SLOTS  = LINE_BYTES / LANES;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int BASE_W = ADDR_W - LANE_W - SLOT_W;

    typedef struct packed {
        seq_state_e        state;
        logic [BASE_W-1:0] base;
        logic [SLOT_W-1:0] start;
        logic [LANE_W-1:0] boff;
        logic [2:0]        size;
        logic              write;
        cyc_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic [CNT_W-1:0]  idx;
        logic              cache;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic [SLOT_W-1:0] rslot;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [CNT_W-1:0]  total;
    logic [SLOT_W-1:0] cur_slot;
    logic [LANES-1:0]  first_en;
    logic              is_rd, mem_kind, grow, burstable, is_last, fin, as_burst;
    cyc_kind_e         new_kind;
    logic              new_write;

    // Decode of the stored request.
    assign is_rd     = !q.write;
    assign mem_kind  = (q.kind == KIND_DATA) || (q.kind == KIND_CODE);
    assign grow      = is_rd && mem_kind && q.cache;
    assign burstable = is_rd && (q.kind != KIND_INTACK) && (q.kind != KIND_HALT);

    bseq_len #(
        .LINE_BYTES (LINE_BYTES),
        .LANES      (LANES),
        .CNT_W      (CNT_W)
    ) u_len (
        .size  (q.size),
        .grow  (grow),
        .count (total)
    );

    bseq_order #(
        .SLOT_W (SLOT_W)
    ) u_order (
        .start (q.start),
        .idx   (q.idx[SLOT_W-1:0]),
        .slot  (cur_slot)
    );

    bseq_lanes #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .size (q.size),
        .off  (q.boff),
        .en   (first_en)
    );

    assign is_last  = (q.idx == total - CNT_W'(1));
    // Completion is sampled only in wait clocks; both inputs low is a plain ready.
    assign fin      = (q.state == ST_WAIT) && (!tgt_done_n || !tgt_burst_n);
    assign as_burst = tgt_done_n && !tgt_burst_n && burstable;
    assign new_kind = cyc_kind_e'(req_kind);

    always_comb begin
        case (new_kind)
            KIND_CODE, KIND_INTACK: new_write = 1'b0;
            KIND_HALT:              new_write = 1'b1;
            default:                new_write = req_write;
        endcase
    end

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_ADDR;
                    d.base  = req_addr[ADDR_W-1:LANE_W+SLOT_W];
                    d.start = req_addr[LANE_W+SLOT_W-1:LANE_W];
                    d.boff  = req_addr[LANE_W-1:0];
                    d.size  = req_size;
                    d.write = new_write;
                    d.kind  = new_kind;
                    d.wdata = req_wdata;
                    d.idx   = '0;
                    d.cache = 1'b0;
                end
            end
            ST_ADDR: begin
                d.state = ST_WAIT;
                if (q.idx == '0) begin
                    d.cache = !tgt_cache_n;
                end
            end
            ST_WAIT: begin
                if (fin) begin
                    if (is_rd) begin
                        d.rvalid = 1'b1;
                        d.rdata  = bus_rdata;
                        d.rslot  = cur_slot;
                    end
                    if (is_last) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.idx   = q.idx + CNT_W'(1);
                        d.state = as_burst ? ST_WAIT : ST_ADDR;
                    end
                end else if (q.idx == '0) begin
                    // Cacheability keeps tracking until the first completion.
                    d.cache = !tgt_cache_n;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign bus_start_n = (q.state != ST_ADDR);
    assign bus_last_n  = !((q.state == ST_WAIT) && is_last);
    assign bus_addr    = {q.base, cur_slot};
    assign bus_lane_n  = (q.idx == '0) ? ~first_en : '0;
    assign bus_write   = q.write;
    assign bus_wdata   = q.wdata;
    assign rd_valid    = q.rvalid;
    assign rd_data     = q.rdata;
    assign rd_slot     = q.rslot;

    always_comb begin
        case (q.kind)
            KIND_CODE:   begin bus_mem = 1'b1; bus_code = 1'b1; end
            KIND_IO:     begin bus_mem = 1'b0; bus_code = 1'b0; end
            KIND_INTACK: begin bus_mem = 1'b0; bus_code = 1'b1; end
            KIND_HALT:   begin bus_mem = 1'b1; bus_code = 1'b0; end
            default:     begin bus_mem = 1'b1; bus_code = 1'b0; end
        endcase
    end

    // R2: the strobe lasts a single clock.
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_start_n |=> bus_start_n);

    // R3: line base and cycle attributes hold throughout a cycle.
    p_line_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE && $past(q.state) != ST_IDLE) |->
        ($stable(bus_addr[ADDR_W-1:LANE_W+SLOT_W]) && $stable(bus_mem) &&
         $stable(bus_code) && $stable(bus_write)));

    // R5: completing the final transfer returns to idle.
    p_last_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_last_n && (!tgt_done_n || !tgt_burst_n)) |=> req_ready);

    // R6: both completion inputs low acts as plain ready, so a strobe follows.
    p_both_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && !tgt_done_n && !tgt_burst_n && bus_last_n) |=> !bus_start_n);

    // R7: a burst completion on a burstable read continues without a strobe.
    p_burst_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && tgt_done_n && !tgt_burst_n && bus_last_n && burstable)
        |=> (bus_start_n && !req_ready));

    // R10: a returned word only follows a wait clock.
    p_word_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(q.state == ST_WAIT));
endmodule

// File: tb/burst_bus_seq_bench.sv
module burst_bus_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_wdata = '0;
    logic        bus_start_n;
    logic [31:2] bus_addr;
    logic [3:0]  bus_lane_n;
    logic        bus_write, bus_mem, bus_code, bus_last_n;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        tgt_done_n = 1'b1;
    logic        tgt_burst_n = 1'b1;
    logic        tgt_cache_n = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  rd_slot;

    int n_checks = 0;
    int n_err    = 0;
    int n_cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_bus_seq u_burst_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_kind(req_kind),
        .req_wdata(req_wdata),
        .bus_start_n(bus_start_n), .bus_addr(bus_addr), .bus_lane_n(bus_lane_n),
        .bus_write(bus_write), .bus_mem(bus_mem), .bus_code(bus_code),
        .bus_last_n(bus_last_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tgt_done_n(tgt_done_n), .tgt_burst_n(tgt_burst_n), .tgt_cache_n(tgt_cache_n),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_slot(rd_slot)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, n_cyc);
        end
    endtask

    function automatic logic [3:0] first_lanes_n(input int size, input int off);
        if (size >= 2) return 4'h0;
        return ~(4'((1 << (1 << size)) - 1) << off);
    endfunction

    // Drives one complete cycle as the target and checks every observable step.
    // pat: 0 all burst, 1 all plain, 2 plain on odd transfers, 3 both on transfer 1.
    task automatic run_cycle(input int kind, input int size, input int slot, input int off,
                             input bit wr, input bit ken_n, input int pat, input int waits);
        logic [27:0] base;
        logic [29:0] exp_addr;
        logic [1:0]  es;
        logic [31:0] word;
        bit eff_write, rd, cacheable, burstable, in_addr, eff_burst, prev_both, both;
        int cnt, wn, term;
        base      = 28'h1234560 + 28'(n_cyc * 7);
        eff_write = (kind == 4) ? 1'b1 : ((kind == 1 || kind == 3) ? 1'b0 : wr);
        rd        = !eff_write;
        cacheable = rd && (kind <= 1) && !ken_n;
        burstable = rd && kind != 3 && kind != 4;
        cnt       = cacheable ? 4 : (size == 4 ? 4 : (size == 3 ? 2 : 1));

        req_valid   = 1'b1;
        req_addr    = {base, slot[1:0], off[1:0]};
        req_size    = size[2:0];
        req_write   = wr;
        req_kind    = kind[2:0];
        req_wdata   = 32'h5A000000 ^ 32'(n_cyc);
        tgt_cache_n = ken_n;
        @(negedge clk);
        req_valid = 1'b0;
        in_addr   = 1'b1;
        prev_both = 1'b0;

        for (int i = 0; i < cnt; i++) begin
            es       = 2'(slot) ^ 2'(i);
            exp_addr = {base, es};
            if (i >= 1) tgt_cache_n = ~ken_n;   // R12: late flips must not matter
            if (in_addr) begin
                if (i == 0) chk("R2 strobe", 64'(bus_start_n), 64'd0);
                else if (prev_both) chk("R6 strobe", 64'(bus_start_n), 64'd0);
                else if (kind == 3 || kind == 4) chk("R8 strobe", 64'(bus_start_n), 64'd0);
                else chk("R7 strobe", 64'(bus_start_n), 64'd0);
                chk("R3 addr", 64'(bus_addr), 64'(exp_addr));
                if (i == 0) begin
                    chk("R11 mem", 64'(bus_mem), 64'(kind == 0 || kind == 1 || kind == 4));
                    chk("R11 code", 64'(bus_code), 64'(kind == 1 || kind == 3));
                    chk("R11 write", 64'(bus_write), 64'(eff_write));
                    chk("R11 wdata", 64'(bus_wdata), 64'(32'h5A000000 ^ 32'(n_cyc)));
                end
                @(negedge clk);
            end
            wn = (waits + i) % 3;
            for (int w = 0; w < wn; w++) begin
                chk("R2 no strobe in wait", 64'(bus_start_n), 64'd1);
                chk("R3 addr held", 64'(bus_addr), 64'(exp_addr));
                @(negedge clk);
            end
            case (pat)
                0: term = 0;
                1: term = 1;
                2: term = (i % 2 == 1) ? 1 : 0;
                default: term = (i == 1) ? 2 : 0;
            endcase
            both        = (term == 2);
            tgt_done_n  = !(term != 0);
            tgt_burst_n = !(term != 1);
            word        = 32'hC0DE0000 ^ 32'(n_cyc << 4) ^ 32'(es);
            bus_rdata   = word;
            if (i == cnt - 1) chk("R5 last low", 64'(bus_last_n), 64'd0);
            else chk("R5 last high", 64'(bus_last_n), 64'd1);
            chk("R3 addr", 64'(bus_addr), 64'(exp_addr));
            chk("R9 lanes", 64'(bus_lane_n), 64'(i == 0 ? first_lanes_n(size, off) : 4'h0));
            @(negedge clk);
            tgt_done_n  = 1'b1;
            tgt_burst_n = 1'b1;
            if (rd) begin
                chk("R10 valid", 64'(rd_valid), 64'd1);
                chk("R10 data", 64'(rd_data), 64'(word));
                chk("R10 slot", 64'(rd_slot), 64'(es));
            end else begin
                chk("R10 no word on write", 64'(rd_valid), 64'd0);
            end
            eff_burst = (term == 0) && burstable;
            prev_both = both;
            if (i == cnt - 1) begin
                chk("R4 count ends cycle", 64'(req_ready), 64'd1);
            end else if (eff_burst) begin
                in_addr = 1'b0;
                chk("R7 burst no strobe", 64'(bus_start_n), 64'd1);
                chk("R4 count continues", 64'(req_ready), 64'd0);
            end else begin
                in_addr = 1'b1;
            end
        end
        tgt_cache_n = 1'b1;
        @(negedge clk);
        chk("R10 single pulse", 64'(rd_valid), 64'd0);
        n_cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 strobe", 64'(bus_start_n), 64'd1);
        chk("R1 last", 64'(bus_last_n), 64'd1);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 64'(req_ready), 64'd1);

        // Reads of memory data and code, all aligned starts, both cache replies.
        for (int kind = 0; kind < 2; kind++)
            for (int size = 0; size < 5; size++)
                for (int slot = 0; slot < 4; slot++)
                    for (int off = 0; off < 4; off++)
                        for (int ken = 0; ken < 2; ken++)
                            for (int pat = 0; pat < 4; pat++) begin
                                if (size <= 2 && (off % (1 << size)) != 0) continue;
                                if (size > 2 && off != 0) continue;
                                if (size == 3 && (slot % 2) != 0) continue;
                                if (size == 4 && slot != 0) continue;
                                run_cycle(kind, size, slot, off, 1'b0, ken[0], pat, slot + pat);
                            end

        // I/O reads never grow (R4).
        for (int size = 0; size < 3; size++)
            for (int pat = 0; pat < 2; pat++)
                run_cycle(2, size, 1, 0, 1'b0, 1'b0, pat, size);

        // Interrupt acknowledge: burst completion acts as plain ready (R8).
        run_cycle(3, 2, 0, 0, 1'b0, 1'b0, 0, 1);
        run_cycle(3, 3, 2, 0, 1'b0, 1'b0, 0, 0);
        run_cycle(3, 3, 0, 0, 1'b0, 1'b0, 3, 2);

        // Writes and halt: single transfer, no returned word.
        for (int kind = 0; kind < 3; kind += 2)
            for (int size = 0; size < 3; size++)
                for (int off = 0; off < 4; off += (1 << size))
                    run_cycle(kind, size, 3, off, 1'b1, 1'b0, 0, off);
        run_cycle(4, 2, 0, 0, 1'b0, 1'b0, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule